// File: doc/BRIEF.md
# Two-Port Combining Switch Node

This node sits at one stage of a processor-to-memory switching network. Two upstream request channels enter, two downstream request channels leave, and one address bit picks the downstream side for each request. Requests bound for different sides pass straight through in the same cycle. Requests that want the same side but name different addresses are arbitrated round-robin.

When both upstream requests name the same address, the node forwards a single request in place of the two. This works for read and write pairs in any mix, and for pairs of fetch-and-add requests, whose increments are summed by a local adder. A small record table, indexed by the forwarded tag, keeps what is needed to answer the second requester. When the single reply comes back, the node produces one reply for each originator in the same cycle. Replies from the two downstream sides are accepted one per cycle.

Opcodes are 0 read, 1 write and 2 fetch-and-add. A forwarded tag is the upstream tag with the originating port index prepended as its top bit.

Top module: `comb_switch`

## Requirements
- R1: A request from port k leaves on output `req_addr[k][ROUTE_BIT]` with tag `{k, req_tag[k]}` and its own opcode and data. Two requests bound for different outputs are both forwarded in the same cycle.
- R2: When two requests with different addresses want the same output, exactly one is forwarded and only its `req_ready` can be high. Port 0 wins first after reset, and the priority moves to the other port after each granted transfer.
- R3: Two fetch-and-add requests to the same address produce one forwarded add on their shared output, carrying the sum of both increments modulo 2^DATA_W and tag `{0, req_tag[0]}`. Both `req_ready` bits follow that output's `fwd_ready` together.
- R4: When the reply v to a combined add returns, port 0 receives v and port 1 receives v plus port 0's increment, in the same cycle and with their own tags.
- R5: Two reads of the same address produce one forwarded read with port 0's tag, and both requesters receive the returned value.
- R6: Two writes to the same address forward only port 1's write (tag `{1, req_tag[1]}`), and both requesters are answered with the returned data.
- R7: A read and a write to the same address forward only the write, under the writer's tag. The writer receives the returned data and the reader receives the write data.
- R8: A fetch-and-add paired with a read or write to the same address is not combined and is arbitrated as in R2.
- R9: At most one downstream reply is accepted per cycle, round-robin starting at output 0 when both are valid. An uncombined reply goes only to the port named by its tag's top bit.
- R10: After reset no request is forwarded and no reply is issued until an input arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Upstream request valid, one bit per port |
| req_ready | output | 2 | Upstream request accepted |
| req_addr | input | 2 x ADDR_W | Request address per port |
| req_op | input | 2 x 2 | Request opcode per port |
| req_data | input | 2 x DATA_W | Write data or increment per port |
| req_tag | input | 2 x TAG_W | Requester tag per port |
| fwd_valid | output | 2 | Downstream request valid per output |
| fwd_ready | input | 2 | Downstream request accepted |
| fwd_addr | output | 2 x ADDR_W | Forwarded address |
| fwd_op | output | 2 x 2 | Forwarded opcode |
| fwd_data | output | 2 x DATA_W | Forwarded data or combined increment |
| fwd_tag | output | 2 x (TAG_W+1) | Forwarded tag: origin port and upstream tag |
| ret_valid | input | 2 | Downstream reply valid per output |
| ret_ready | output | 2 | Downstream reply accepted |
| ret_data | input | 2 x DATA_W | Reply data |
| ret_tag | input | 2 x (TAG_W+1) | Reply tag, as forwarded |
| rsp_valid | output | 2 | Upstream reply valid per port |
| rsp_data | output | 2 x DATA_W | Upstream reply data |
| rsp_tag | output | 2 x TAG_W | Upstream reply tag |

## Verification
Two of the node's functions can fall in the same cycle. A new pair can be combined and written into the record table while an earlier reply is being split from it. Separately, both downstream outputs can present replies together and compete for the single reply path. The bench makes the second case happen by sending two independent requests, then returning both replies in one cycle. It expects the round-robin side to be served first and the other side one cycle later. Random same-address pairs over every opcode mix are checked against expected forwarded and split values computed in bench functions.

// File: rtl/comb_switch.sv
module comb_switch #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 2,
  parameter int ROUTE_BIT = 0
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  req_valid,
  output logic [1:0]                  req_ready,
  input  logic [1:0][ADDR_W-1:0]      req_addr,
  input  logic [1:0][1:0]             req_op,
  input  logic [1:0][DATA_W-1:0]      req_data,
  input  logic [1:0][TAG_W-1:0]       req_tag,
  output logic [1:0]                  fwd_valid,
  input  logic [1:0]                  fwd_ready,
  output logic [1:0][ADDR_W-1:0]      fwd_addr,
  output logic [1:0][1:0]             fwd_op,
  output logic [1:0][DATA_W-1:0]      fwd_data,
  output logic [1:0][TAG_W:0]         fwd_tag,
  input  logic [1:0]                  ret_valid,
  output logic [1:0]                  ret_ready,
  input  logic [1:0][DATA_W-1:0]      ret_data,
  input  logic [1:0][TAG_W:0]         ret_tag,
  output logic [1:0]                  rsp_valid,
  output logic [1:0][DATA_W-1:0]      rsp_data,
  output logic [1:0][TAG_W-1:0]       rsp_tag
);
  localparam int IW  = TAG_W + 1;
  localparam int ENT = 1 << IW;
  localparam logic [1:0] OP_WR = 2'd1, OP_ADD = 2'd2;
  localparam logic [1:0] M_COPY = 2'd0, M_ADD = 2'd1, M_WDATA = 2'd2;

  logic [1:0] dst, grant, fire, cmb;
  logic same, combine, clash, win, ptr, rptr;
  logic [DATA_W-1:0] cdata, cval;
  logic [1:0] cmode;

  logic [ENT-1:0]    tv, tc;
  logic [TAG_W-1:0]  tot  [ENT];
  logic [1:0]        tm   [ENT];
  logic [DATA_W-1:0] tval [ENT];

  assign dst     = {req_addr[1][ROUTE_BIT], req_addr[0][ROUTE_BIT]};
  assign same    = (req_valid == 2'b11) && (req_addr[0] == req_addr[1]);
  assign combine = same && ((req_op[0] == OP_ADD) == (req_op[1] == OP_ADD));
  assign clash   = (req_valid == 2'b11) && (dst[0] == dst[1]) && !combine;
  assign win     = (req_op[1] == OP_WR);
  assign cdata   = (req_op[0] == OP_ADD) ? req_data[0] + req_data[1] : req_data[win];
  assign cval    = (req_op[0] == OP_ADD) ? req_data[0] : req_data[win];
  assign cmode   = (req_op[0] == OP_ADD) ? M_ADD :
                   (req_op[0] != req_op[1]) ? M_WDATA : M_COPY;

  always_comb begin
    for (int i = 0; i < 2; i++)
      grant[i] = req_valid[i] && (combine ? (i == 0) : clash ? (ptr == i[0]) : 1'b1);
  end

  always_comb begin
    fwd_valid = '0;
    fwd_addr  = '0;
    fwd_op    = '0;
    fwd_data  = '0;
    fwd_tag   = '0;
    for (int j = 0; j < 2; j++)
      for (int i = 0; i < 2; i++)
        if (grant[i] && dst[i] == j[0]) begin
          fwd_valid[j] = 1'b1;
          fwd_addr[j]  = req_addr[i];
          if (combine) begin
            fwd_op[j]   = req_op[win];
            fwd_data[j] = cdata;
            fwd_tag[j]  = {win, req_tag[win]};
          end else begin
            fwd_op[j]   = req_op[i];
            fwd_data[j] = req_data[i];
            fwd_tag[j]  = {i[0], req_tag[i]};
          end
        end
  end

  always_comb begin
    for (int i = 0; i < 2; i++)
      req_ready[i] = combine ? fwd_ready[dst[0]] : (grant[i] && fwd_ready[dst[i]]);
  end

  assign fire = fwd_valid & fwd_ready;
  assign cmb  = {combine && dst[0], combine && !dst[0]};

  logic take, sel, p;
  logic [IW-1:0]     rt;
  logic [DATA_W-1:0] rv;

  assign take      = |ret_valid;
  assign sel       = (ret_valid == 2'b11) ? rptr : ret_valid[1];
  assign ret_ready = {take && sel, take && !sel};
  assign rt        = ret_tag[sel];
  assign rv        = ret_data[sel];
  assign p         = rt[TAG_W];

  always_comb begin
    rsp_valid = '0;
    rsp_data  = '0;
    rsp_tag   = '0;
    if (take) begin
      rsp_valid[p] = 1'b1;
      rsp_tag[p]   = rt[TAG_W-1:0];
      rsp_data[p]  = rv;
      if (tv[rt] && tc[rt]) begin
        rsp_valid[~p] = 1'b1;
        rsp_tag[~p]   = tot[rt];
        case (tm[rt])
          M_ADD:   rsp_data[~p] = rv + tval[rt];
          M_WDATA: rsp_data[~p] = tval[rt];
          default: rsp_data[~p] = rv;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= 1'b0;
      rptr <= 1'b0;
      tv   <= '0;
      tc   <= '0;
    end else begin
      if (clash && req_valid[ptr] && req_ready[ptr]) ptr <= ~ptr;
      if (ret_valid == 2'b11) rptr <= ~sel;
      for (int e = 0; e < ENT; e++) begin
        if (fire[0] && fwd_tag[0] == IW'(e)) begin
          tv[e] <= 1'b1;
          tc[e] <= cmb[0];
        end else if (fire[1] && fwd_tag[1] == IW'(e)) begin
          tv[e] <= 1'b1;
          tc[e] <= cmb[1];
        end else if (take && rt == IW'(e)) begin
          tv[e] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENT; e++)
      if ((fire[0] && fwd_tag[0] == IW'(e)) || (fire[1] && fwd_tag[1] == IW'(e))) begin
        tot[e]  <= req_tag[~win];
        tm[e]   <= cmode;
        tval[e] <= cval;
      end
  end
endmodule

// File: rtl/comb_switch_chk.sv
module comb_switch_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int ROUTE_BIT = 0
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             req_valid,
  input logic [1:0]             req_ready,
  input logic [1:0][ADDR_W-1:0] req_addr,
  input logic [1:0][1:0]        req_op,
  input logic [1:0][DATA_W-1:0] req_data,
  input logic [1:0]             fwd_valid,
  input logic [1:0][DATA_W-1:0] fwd_data,
  input logic [1:0]             ret_valid,
  input logic [1:0]             ret_ready,
  input logic [1:0]             rsp_valid
);
  logic both, samed, diff_addr, split_pair;
  assign both       = req_valid == 2'b11;
  assign samed      = req_addr[0][ROUTE_BIT] == req_addr[1][ROUTE_BIT];
  assign diff_addr  = req_addr[0] != req_addr[1];
  assign split_pair = both && samed && diff_addr;

  // R1
  route_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !samed) |-> (fwd_valid == 2'b11));

  // R2
  one_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_pair |-> (req_ready != 2'b11));

  // R2
  rr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split_pair && req_ready[0]) |=> (split_pair |-> !req_ready[0]));

  // R3
  comb_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !diff_addr && req_op[0] == 2'd2 && req_op[1] == 2'd2) |->
      (fwd_valid[req_addr[0][ROUTE_BIT]] && $countones(fwd_valid) == 1 &&
       fwd_data[req_addr[0][ROUTE_BIT]] == DATA_W'(req_data[0] + req_data[1])));

  // R9
  ret_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ret_ready));

  // R9
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> (|(ret_valid & ret_ready)));

  // R10
  fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fwd_valid) |-> (|req_valid));
endmodule

bind comb_switch comb_switch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROUTE_BIT(ROUTE_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_op(req_op), .req_data(req_data),
  .fwd_valid(fwd_valid), .fwd_data(fwd_data),
  .ret_valid(ret_valid), .ret_ready(ret_ready), .rsp_valid(rsp_valid)
);

// File: tb/test_comb_switch.sv
module test_comb_switch;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] req_valid = 0, req_ready, fwd_valid, fwd_ready = 0;
  logic [1:0] ret_valid = 0, ret_ready, rsp_valid;
  logic [1:0][7:0]  req_addr = '0, fwd_addr;
  logic [1:0][1:0]  req_op = '0, fwd_op;
  logic [1:0][15:0] req_data = '0, fwd_data, ret_data = '0, rsp_data;
  logic [1:0][1:0]  req_tag = '0, rsp_tag;
  logic [1:0][2:0]  fwd_tag, ret_tag = '0;

  int checks = 0, errors = 0;
  bit ptr_m = 0, rptr_m = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comb_switch i_comb_switch (.*);

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] split_val(input logic [1:0][1:0] o, input logic [1:0][15:0] d,
                                            input bit w, input logic [15:0] v);
    if (o[0] == 2'd2) return v + d[0];
    if (o[0] != o[1]) return d[w];
    return v;
  endfunction

  task automatic ret1(input int j, input logic [2:0] tg, input logic [15:0] v,
                      input logic [1:0] ev, input logic [1:0][1:0] et,
                      input logic [1:0][15:0] ed, input string r);
    @(negedge clk);
    ret_valid = '0; ret_valid[j] = 1'b1; ret_tag[j] = tg; ret_data[j] = v;
    #1;
    chk(rsp_valid == ev, r, rsp_valid, ev);
    for (int k = 0; k < 2; k++)
      if (ev[k]) begin
        chk(rsp_tag[k] == et[k], r, rsp_tag[k], et[k]);
        chk(rsp_data[k] == ed[k], r, rsp_data[k], ed[k]);
      end
    @(posedge clk); #1;
    ret_valid = '0;
  endtask

  task automatic trial(input logic [1:0] v, input logic [1:0][7:0] a, input logic [1:0][1:0] o,
                       input logic [1:0][15:0] d, input logic [1:0][1:0] t);
    logic [1:0] dst, ev;
    logic [1:0][1:0] et;
    logic [1:0][15:0] ed;
    logic [15:0] vr, fd;
    bit comb, clsh, w, g;
    int j;
    string r;
    dst  = {a[1][0], a[0][0]};
    comb = (v == 2'b11) && (a[0] == a[1]) && ((o[0] == 2'd2) == (o[1] == 2'd2));
    clsh = (v == 2'b11) && (dst[0] == dst[1]) && !comb;
    w    = (o[1] == 2'd1);
    @(negedge clk);
    req_valid = v; req_addr = a; req_op = o; req_data = d; req_tag = t; fwd_ready = 2'b11;
    #1;
    if (comb) begin
      r  = (o[0] == 2'd2) ? "R3" : (o[0] != o[1]) ? "R7" : (o[0] == 2'd1) ? "R6" : "R5";
      j  = dst[0];
      fd = (o[0] == 2'd2) ? d[0] + d[1] : d[w];
      chk(fwd_valid == (2'b01 << j), r, fwd_valid, 2'b01 << j);
      chk(fwd_op[j] == o[w], r, fwd_op[j], o[w]);
      chk(fwd_data[j] == fd, r, fwd_data[j], fd);
      chk(fwd_tag[j] == {w, t[w]}, r, fwd_tag[j], {w, t[w]});
      chk(req_ready == 2'b11, r, req_ready, 2'b11);
      @(posedge clk); #1; req_valid = '0;
      vr = 16'($urandom);
      ev = 2'b11; et = t;
      ed[w] = vr; ed[~w] = split_val(o, d, w, vr);
      ret1(j, {w, t[w]}, vr, ev, et, ed, (o[0] == 2'd2) ? "R4" : r);
    end else if (clsh) begin
      r = (a[0] == a[1]) ? "R8" : "R2";
      g = ptr_m; j = dst[0];
      chk(fwd_valid == (2'b01 << j), r, fwd_valid, 2'b01 << j);
      chk(fwd_tag[j] == {g, t[g]}, r, fwd_tag[j], {g, t[g]});
      chk(fwd_data[j] == d[g], r, fwd_data[j], d[g]);
      chk(req_ready == (2'b01 << g), r, req_ready, 2'b01 << g);
      @(posedge clk); #1; req_valid = '0; ptr_m = ~ptr_m;
      vr = 16'($urandom);
      ev = 2'b01 << g; et = t; ed = '0; ed[g] = vr;
      ret1(j, {g, t[g]}, vr, ev, et, ed, "R9");
    end else begin
      for (int k = 0; k < 2; k++)
        if (v[k]) begin
          chk(fwd_valid[dst[k]] == 1'b1, "R1", fwd_valid, 2'b01 << dst[k]);
          chk(fwd_tag[dst[k]] == {k[0], t[k]}, "R1", fwd_tag[dst[k]], {k[0], t[k]});
          chk(fwd_data[dst[k]] == d[k], "R1", fwd_data[dst[k]], d[k]);
        end
      chk(req_ready == v, "R1", req_ready, v);
      @(posedge clk); #1; req_valid = '0;
      for (int k = 0; k < 2; k++)
        if (v[k]) begin
          vr = 16'($urandom);
          ev = 2'b01 << k; et = t; ed = '0; ed[k] = vr;
          ret1(dst[k], {k[0], t[k]}, vr, ev, et, ed, "R9");
        end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10
    chk(fwd_valid == 2'b00, "R10", fwd_valid, 0);
    chk(rsp_valid == 2'b00, "R10", rsp_valid, 0);
    chk(req_ready == 2'b00, "R10", req_ready, 0);

    // R3: backpressure holds both requesters of a combined add
    req_valid = 2'b11; req_addr = {8'h24, 8'h24}; req_op = {2'd2, 2'd2};
    req_data = {16'h0003, 16'h0005}; req_tag = {2'd1, 2'd2}; fwd_ready = 2'b00;
    #1;
    chk(req_ready == 2'b00, "R3", req_ready, 0);
    chk(fwd_valid == 2'b01, "R3", fwd_valid, 1);
    chk(fwd_data[0] == 16'h0008, "R3", fwd_data[0], 16'h0008);
    @(negedge clk); req_valid = '0;

    // directed corners: add overflow, each read/write mix, mismatched op, clash
    trial(2'b11, {8'h11, 8'h11}, {2'd2, 2'd2}, {16'h0002, 16'hFFFF}, {2'd3, 2'd0});
    trial(2'b11, {8'h30, 8'h30}, {2'd0, 2'd0}, {16'h0, 16'h0}, {2'd1, 2'd1});
    trial(2'b11, {8'h30, 8'h30}, {2'd1, 2'd1}, {16'hAAAA, 16'h5555}, {2'd2, 2'd0});
    trial(2'b11, {8'h30, 8'h30}, {2'd1, 2'd0}, {16'h1234, 16'h0}, {2'd0, 2'd3});
    trial(2'b11, {8'h30, 8'h30}, {2'd0, 2'd1}, {16'h0, 16'h4321}, {2'd2, 2'd1});
    trial(2'b11, {8'h30, 8'h30}, {2'd2, 2'd0}, {16'h0009, 16'h0}, {2'd0, 2'd0});
    trial(2'b11, {8'h02, 8'h04}, {2'd1, 2'd0}, {16'h00AA, 16'h0}, {2'd1, 2'd2});
    trial(2'b11, {8'h02, 8'h04}, {2'd1, 2'd0}, {16'h00AA, 16'h0}, {2'd1, 2'd2});
    trial(2'b11, {8'h01, 8'h04}, {2'd0, 2'd0}, {16'h0, 16'h0}, {2'd3, 2'd3});

    // R9: both replies arrive in one cycle
    trial(2'b11, {8'h07, 8'h06}, {2'd0, 2'd0}, {16'h0, 16'h0}, {2'd2, 2'd1});
    @(negedge clk);
    req_valid = 2'b11; req_addr = {8'h05, 8'h08}; req_op = '0; req_tag = {2'd0, 2'd1};
    @(posedge clk); #1; req_valid = '0;
    @(negedge clk);
    ret_valid = 2'b11; ret_tag = {3'b100, 3'b001}; ret_data = {16'hBEEF, 16'hCAFE};
    #1;
    chk(ret_ready == (2'b01 << rptr_m), "R9", ret_ready, 2'b01 << rptr_m);
    chk(rsp_valid == (rptr_m ? 2'b10 : 2'b01), "R9", rsp_valid, rptr_m ? 2'b10 : 2'b01);
    @(posedge clk); #1;
    ret_valid[rptr_m] = 1'b0; rptr_m = ~rptr_m;
    @(negedge clk); #1;
    chk(ret_ready == (2'b01 << rptr_m), "R9", ret_ready, 2'b01 << rptr_m);
    chk(rsp_data[rptr_m] == (rptr_m ? 16'hBEEF : 16'hCAFE), "R9", rsp_data[rptr_m],
        rptr_m ? 16'hBEEF : 16'hCAFE);
    @(posedge clk); #1; ret_valid = '0;

    for (int n = 0; n < 400; n++) begin
      logic [1:0] v;
      logic [1:0][7:0] a;
      logic [1:0][1:0] o, t;
      logic [1:0][15:0] d;
      v = 2'($urandom_range(1, 3));
      if (($urandom % 4) != 0) v = 2'b11;
      for (int k = 0; k < 2; k++) begin
        a[k] = 8'($urandom % 4);
        o[k] = 2'($urandom % 3);
        d[k] = 16'($urandom);
        t[k] = 2'($urandom);
      end
      if (($urandom % 2) != 0) a[1] = a[0];
      trial(v, a, o, d, t);
    end
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule